// File: doc/BRIEF.md
# Byte-Lane Adapter for a Word-Only Register Window

This block connects a host port that issues 1-, 2- or 4-byte accesses at any byte offset to a 128-byte register window. The registers in that window only take aligned 32-bit accesses. The adapter turns every host access into a word access. On a write, it reads the addressed word and overlays only the new bytes before it writes the whole word back. On a read, it moves the addressed bytes down to bit 0 and clears the bits above the access width.

The adapter also splits the window into three regions: a 16-word core bank, an 8-word DMA bank and one control word. Any other offset is a hole. The banks are modelled as plain word-wide storage stubs, so that the adapter can be exercised end to end through its own port. Each write completes at the clock edge that accepts it. Each read returns its data one cycle after it is accepted.

Top module: `bytelane_adapter`

## Requirements
- R1: After reset, every word of the three regions reads as zero and `rsp_valid` is low.
- R2: Offsets 0x00–0x3F select core word `addr>>2`. Offsets 0x40–0x5F select DMA word `(addr-0x40)>>2`. Offsets 0x70–0x73 select the control word. Each region keeps its own contents.
- R3: `req_size` encodes the access width: 0 is one byte, 1 is two bytes, and both 2 and 3 are four bytes.
- R4: A read accepted at clock edge N raises `rsp_valid` after edge N for exactly one cycle. `rsp_rdata` then holds the word shifted right by `8*(addr&3)` and masked to the access width. The read changes no register.
- R5: A four-byte write at an offset whose low two bits are zero replaces the whole addressed word.
- R6: A narrower or misaligned write places its low-order data bytes into lanes starting at `addr&3`. Every other lane keeps its previous value.
- R7: An access that would run past the end of its 4-byte word is cut at that word boundary, for both reads and writes. No lane of the next word is touched or returned.
- R8: A read at an unmapped offset (0x60–0x6F, 0x74–0x7F) returns zero. A write there changes no register.
- R9: The window is little-endian: the byte at the lowest offset of a word is bits 7:0 of that word.
- R10: A write produces no response: `rsp_valid` stays low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, taken on every rising edge at which it is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte offset in the window |
| req_size | input | 2 | Access width code (see R3) |
| req_wdata | input | 32 | Write data, right-aligned (first byte in bits 7:0) |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data, right-aligned and zero-extended |

## Verification
A wrong lane mask or shift inside the merge corrupts the lanes that a write should have left alone. That damage only shows up at the ports when the word is next read, one cycle after that read is accepted. For this reason, every write in the sweep is followed at once by a read of the same access and by a read of the full aligned word. A region decode error shows up as data in the wrong bank, or as non-zero data from a hole. The final readback of every word catches it.

// File: rtl/lane_pkg.sv
package lane_pkg;

    localparam int ADDR_W     = 7;
    localparam int WORD_W     = 32;
    localparam int LANES      = WORD_W / 8;
    localparam int OFF_W      = $clog2(LANES);
    localparam int CORE_WORDS = 16;
    localparam int DMA_WORDS  = 8;
    localparam int CTRL_WORDS = 1;
    localparam int IDX_W      = $clog2(CORE_WORDS);

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_CORE = 2'd1,
        RGN_DMA  = 2'd2,
        RGN_CTRL = 2'd3
    } region_e;

    typedef struct packed {
        region_e            rgn;
        logic [IDX_W-1:0]   idx;
    } target_t;

    // width code to byte count: 0->1, 1->2, 2/3->4
    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // lanes touched by an access; bits beyond lane 3 fall off (boundary cut)
    function automatic logic [LANES-1:0] lane_mask(input logic [OFF_W-1:0] off,
                                                   input logic [1:0] code);
        logic [2*LANES-1:0] run;
        run = ((2*LANES)'(1) << size_bytes(code)) - (2*LANES)'(1);
        run = run << off;
        return run[LANES-1:0];
    endfunction

    function automatic logic [WORD_W-1:0] width_mask(input logic [1:0] code);
        case (code)
            2'd0:    return WORD_W'(32'h0000_00FF);
            2'd1:    return WORD_W'(32'h0000_FFFF);
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/window_decode.sv
module window_decode
    import lane_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output target_t           tgt
);
    always_comb begin
        tgt = '{rgn: RGN_NONE, idx: '0};
        if (addr[6] == 1'b0) begin
            tgt.rgn = RGN_CORE;
            tgt.idx = addr[5:2];
        end else if (addr[6:5] == 2'b10) begin
            tgt.rgn = RGN_DMA;
            tgt.idx = {1'b0, addr[4:2]};
        end else if (addr[6:2] == 5'b11100) begin
            tgt.rgn = RGN_CTRL;
        end
    end
endmodule

// File: rtl/lane_merge.sv
module lane_merge
    import lane_pkg::*;
(
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        size,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] cur,
    output logic [WORD_W-1:0] merged,
    output logic [WORD_W-1:0] extract
);
    logic [LANES-1:0]  sel;
    logic [WORD_W-1:0] placed;

    always_comb begin
        sel     = lane_mask(off, size);
        placed  = wdata << {off, 3'b000};
        extract = (cur >> {off, 3'b000}) & width_mask(size);
    end

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign merged[8*b +: 8] = sel[b] ? placed[8*b +: 8] : cur[8*b +: 8];
    end
endmodule

// File: rtl/word_stub.sv
module word_stub
    import lane_pkg::*;
#(
    parameter  int WORDS = 16,
    localparam int SEL_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data
);
    if (WORDS == 1) begin : g_single
        logic [WORD_W-1:0] word_q;
        logic              unused_sel;
        assign unused_sel = ^sel;
        always_ff @(posedge clk) begin
            if (rst)        word_q <= '0;
            else if (wr_en) word_q <= wr_data;
        end
        assign rd_data = word_q;
    end else begin : g_bank
        logic [WORD_W-1:0] mem_q [WORDS];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
            end else if (wr_en) begin
                mem_q[sel] <= wr_data;
            end
        end
        assign rd_data = mem_q[sel];
    end
endmodule

// File: rtl/bytelane_adapter.sv
module bytelane_adapter
    import lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [6:0]        req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata
);
    target_t           tgt;
    logic [WORD_W-1:0] core_rd, dma_rd, ctrl_rd, cur_word, merged, extract;
    logic              wr_go;

    window_decode u_dec (.addr(req_addr), .tgt(tgt));

    assign wr_go = req_valid && req_write;

    word_stub #(.WORDS(CORE_WORDS)) u_core (
        .clk(clk), .rst(rst),
        .wr_en(wr_go && tgt.rgn == RGN_CORE),
        .sel(tgt.idx[3:0]), .wr_data(merged), .rd_data(core_rd));

    word_stub #(.WORDS(DMA_WORDS)) u_dma (
        .clk(clk), .rst(rst),
        .wr_en(wr_go && tgt.rgn == RGN_DMA),
        .sel(tgt.idx[2:0]), .wr_data(merged), .rd_data(dma_rd));

    word_stub #(.WORDS(CTRL_WORDS)) u_ctrl (
        .clk(clk), .rst(rst),
        .wr_en(wr_go && tgt.rgn == RGN_CTRL),
        .sel(tgt.idx[0:0]), .wr_data(merged), .rd_data(ctrl_rd));

    always_comb begin
        case (tgt.rgn)
            RGN_CORE: cur_word = core_rd;
            RGN_DMA:  cur_word = dma_rd;
            RGN_CTRL: cur_word = ctrl_rd;
            default:  cur_word = '0;
        endcase
    end

    lane_merge u_merge (
        .off(req_addr[OFF_W-1:0]), .size(req_size), .wdata(req_wdata),
        .cur(cur_word), .merged(merged), .extract(extract));

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rsp_rdata <= (req_valid && !req_write) ? extract : '0;
        end
    end

    // R4: a read is answered in the next cycle
    a_r4_read_answered: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    // R10: no response after a write or an idle cycle
    a_r10_no_write_rsp: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || req_write) |=> !rsp_valid);

    // R8: holes read as zero
    a_r8_hole_zero: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write &&
         (req_addr[6:4] == 3'b110 || (req_addr[6:4] == 3'b111 && req_addr[3:2] != 2'b00)))
        |=> rsp_rdata == 32'd0);

    // R7: a read from the top lane returns a single byte at most
    a_r7_cut_at_word: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_addr[1:0] == 2'b11) |=> rsp_rdata[31:8] == 24'd0);

    // R3: a byte read is zero-extended
    a_r3_byte_width: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_size == 2'd0) |=> rsp_rdata[31:8] == 24'd0);
endmodule

// File: tb/sim_bytelane_adapter.sv
`timescale 1ns/1ps
module sim_bytelane_adapter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [128];

    always #2 clk = ~clk;

    bytelane_adapter u0 (.clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

    function automatic bit mapped(input int a);
        return (a < 'h60) || (a >= 'h70 && a < 'h74);
    endfunction

    function automatic int nbytes(input int a, input logic [1:0] s);
        int n;
        n = (s == 0) ? 1 : (s == 1) ? 2 : 4;
        if ((a % 4) + n > 4) n = 4 - (a % 4);
        return n;
    endfunction

    function automatic logic [31:0] expect_rd(input int a, input logic [1:0] s);
        logic [31:0] v = '0;
        for (int i = 0; i < nbytes(a, s); i++)
            if (mapped(a + i)) v[8*i +: 8] = model[a + i];
        return v;
    endfunction

    task automatic model_wr(input int a, input logic [1:0] s, input logic [31:0] d);
        for (int i = 0; i < nbytes(a, s); i++)
            if (mapped(a + i)) model[a + i] = d[8*i +: 8];
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic op(input logic w, input int a, input logic [1:0] s, input logic [31:0] d,
                      output logic rv, output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = 7'(a); req_size = s; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        rv = rsp_valid; rd = rsp_rdata;
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [1:0] s);
        logic rv; logic [31:0] rd;
        op(1'b0, a, s, 32'd0, rv, rd);
        check({tag, "/R4 valid"}, {31'd0, rv}, 32'd1);
        check(tag, rd, expect_rd(a, s));
    endtask

    task automatic wr_do(input int a, input logic [1:0] s, input logic [31:0] d);
        logic rv; logic [31:0] rd;
        op(1'b1, a, s, d, rv, rd);
        check("R10 no response on write", {31'd0, rv}, 32'd0);
        model_wr(a, s, d);
    endtask

    function automatic string tag_of(input int a, input logic [1:0] s);
        int n;
        n = (s == 0) ? 1 : (s == 1) ? 2 : 4;
        if (!mapped(a))            return "R8 hole";
        if ((a % 4) + n > 4)       return "R7 boundary cut";
        if (n == 4)                return "R5 full word";
        return "R6 lane merge";
    endfunction

    initial begin
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        for (int w = 0; w < 32; w++) rd_chk("R1 reset zero", 4*w, 2'd2);

        // R9: little-endian lane order
        wr_do('h00, 2'd2, 32'h4433_2211);
        rd_chk("R9 lowest byte", 'h00, 2'd0);
        rd_chk("R9 byte 1", 'h01, 2'd0);
        check("R9 byte 1 literal", expect_rd('h01, 2'd0), 32'h0000_0022);
        // R2: regions are separate
        wr_do('h40, 2'd2, 32'hD0D0_0001);
        wr_do('h70, 2'd2, 32'hC7C7_0002);
        rd_chk("R2 core word 0", 'h00, 2'd2);
        rd_chk("R2 dma word 0", 'h40, 2'd2);
        rd_chk("R2 control word", 'h70, 2'd2);
        rd_chk("R2 dma last word", 'h5C, 2'd2);

        // near-exhaustive sweep: every offset x every width code
        for (int a = 0; a < 128; a++) begin
            for (int s = 0; s < 4; s++) begin
                logic [31:0] d;
                d = {8'(a), 8'(s) ^ 8'hA5, ~8'(a), 8'(a * 7 + s)};
                wr_do(a, 2'(s), d);
                rd_chk({tag_of(a, 2'(s)), " /R3"}, a, 2'(s));
                rd_chk({tag_of(a, 2'(s)), " word"}, a & ~3, 2'd2);
            end
        end

        // R8: hole writes leave every mapped word as modelled
        for (int a = 'h60; a < 'h80; a++)
            if (!mapped(a)) wr_do(a, 2'd2, 32'hFFFF_FFFF);
        for (int w = 0; w < 32; w++) rd_chk("R8 final readback", 4*w, 2'd2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule